// File: doc/BRIEF.md
# Machine-Cycle and Clock-State Ring Sequencer

This block paces an 8-bit processor core. It holds two one-hot rings. The machine-cycle ring marks which of five machine cycles (M1 to M5) is in progress. The clock-state ring marks which of up to six clock states (T1 to T6) within that machine cycle is current. On every clock the clock-state ring moves one position. When the last clock state of the cycle is reached, the clock-state ring returns to T1 and the machine-cycle ring loads the cycle chosen by the decoder. That choice can be any of M1 to M5, so unused cycles can be jumped over. For example, a stack pop can run M1, then M4, then M5. Choosing M1 ends the instruction and starts the next opcode fetch.

The decoder gives the length of each machine cycle as a 2-bit code. A wait request inserts stall clocks. While stalled, every bit of the clock-state ring reads zero. The sequencer keeps the clock state it will resume into internally, and restores it when the wait is dropped.

The controller is a two-state machine. SEQ_RUN moves the rings forward. SEQ_STALL holds them. Transitions: SEQ_RUN to SEQ_STALL when wait_req is high at a clock edge; SEQ_STALL to SEQ_RUN when wait_req is low at a clock edge; otherwise the state is kept.

Top module: `mt_ring_sequencer`

## Requirements
- R1: While rst_n is low, m_ring is 5'b00001 (M1), t_ring is 6'b000001 (T1) and the sequencer is not stalled.
- R2: In SEQ_RUN, before the last clock state of the cycle, each clock edge moves t_ring's single set bit up by one position (bit 0 = T1 ... bit 5 = T6). No state is skipped.
- R3: cyc_len codes 0, 1, 2 and 3 give cycles of 3, 4, 5 and 6 clock states. At the clock edge where the current state is the last one (or a later one), t_ring returns to T1.
- R4: At that same cycle-ending edge, m_ring becomes one-hot at bit next_m, where next_m 0 to 4 selects M1 to M5. Any order is allowed, for example M1 then M4 then M5.
- R5: A next_m value of 5, 6 or 7 at a cycle-ending edge selects M1.
- R6: A clock edge in SEQ_RUN with wait_req high enters SEQ_STALL. That edge still moves the rings forward as in R2 to R4. t_ring then reads all zeros for as long as the stall lasts.
- R7: The first clock edge in SEQ_STALL with wait_req low returns to SEQ_RUN. t_ring shows exactly the state reached at the stall-entry edge. m_ring does not change during any edge taken in SEQ_STALL.
- R8: Outside a stall, m_ring and t_ring each have exactly one bit set.
- R9: next_m and cyc_len values present at an edge that does not end a cycle have no effect on m_ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Wait request, internal or external |
| cyc_len | input | 2 | Length code of the current machine cycle (0 to 3 means 3 to 6 states) |
| next_m | input | 3 | Machine cycle to load at cycle end (0 to 4 means M1 to M5; 5 to 7 means M1) |
| m_ring | output | 5 | One-hot machine-cycle ring, bit 0 = M1 |
| t_ring | output | 6 | One-hot clock-state ring, bit 0 = T1; all zeros while stalled |

## Verification
Every result is registered, so a change on wait_req, cyc_len or next_m shows on m_ring and t_ring exactly one clock edge later. This holds for a T step, a cycle wrap, a new M cycle, the blanking at stall entry and the restore at release. The bench drives inputs on the falling edge and steps its arithmetic model of ring indices and stall flag once per rising edge. It compares both rings on the next falling edge, so each check sees the value produced by the single rising edge in between. The sweeps cover every length code against every next_m value, stalls of one to three clocks starting at each position of a six-state cycle, and a long pseudo-random run that changes inputs in the middle of cycles.

// File: rtl/mt_seq_pkg.sv
package mt_seq_pkg;
    localparam int NUM_M_CYCLES = 5;
    localparam int NUM_T_STATES = 6;
    localparam int MIN_T_STATES = 3;

    typedef enum logic {
        SEQ_RUN   = 1'b0,
        SEQ_STALL = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mt_wait_fsm.sv
module mt_wait_fsm
    import mt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_req,
    output logic stalled
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RUN:   if (wait_req)  state_d = SEQ_STALL;
            SEQ_STALL: if (!wait_req) state_d = SEQ_RUN;
            default:   state_d = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        stalled = (state_q == SEQ_STALL);
    end

    // R6: a wait request seen while running always produces a stall
    a_r6_enter_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!stalled && wait_req) |=> stalled);
endmodule

// File: rtl/mt_tstate_ring.sv
module mt_tstate_ring #(
    parameter int NUM_T = 6,
    parameter int T_MIN = 3,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [LEN_W-1:0] cyc_len,
    output logic [NUM_T-1:0] t_cur,
    output logic             cycle_end
);
    localparam int IDX_W = $clog2(NUM_T);

    logic [IDX_W-1:0] last_idx;
    logic [NUM_T-1:0] at_or_past_last;
    logic [NUM_T-1:0] t_next;

    always_comb begin
        last_idx = IDX_W'(cyc_len) + IDX_W'(T_MIN - 1);
    end

    for (genvar g = 0; g < NUM_T; g++) begin : g_last
        assign at_or_past_last[g] = (IDX_W'(g) >= last_idx);
    end

    always_comb begin
        cycle_end = advance && |(t_cur & at_or_past_last);
        if (!advance)      t_next = t_cur;
        else if (cycle_end) t_next = NUM_T'(1);
        else               t_next = t_cur << 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_cur <= NUM_T'(1);
        else        t_cur <= t_next;
    end

    // R2: inside a cycle the state moves up exactly one position
    a_r2_t_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !cycle_end) |=> (t_cur == ($past(t_cur) << 1)));
    // R3: a finished cycle always restarts at T1
    a_r3_t_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (t_cur == NUM_T'(1)));
endmodule

// File: rtl/mt_mcycle_ring.sv
module mt_mcycle_ring #(
    parameter int NUM_M = 5,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] next_sel,
    output logic [NUM_M-1:0] m_cur
);
    logic [NUM_M-1:0] sel_hot;
    logic [NUM_M-1:0] m_load;

    for (genvar g = 0; g < NUM_M; g++) begin : g_sel
        assign sel_hot[g] = (next_sel == SEL_W'(g));
    end

    always_comb begin
        m_load = (sel_hot == '0) ? NUM_M'(1) : sel_hot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    m_cur <= NUM_M'(1);
        else if (load) m_cur <= m_load;
    end

    // R9: no cycle end, no machine-cycle change
    a_r9_m_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(m_cur));
    // R5: out-of-range selections fall back to M1
    a_r5_m_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (load && next_sel >= SEL_W'(NUM_M)) |=> m_cur[0]);
endmodule

// File: rtl/mt_ring_sequencer.sv
module mt_ring_sequencer
    import mt_seq_pkg::*;
#(
    parameter int NUM_M = NUM_M_CYCLES,
    parameter int NUM_T = NUM_T_STATES,
    parameter int T_MIN = MIN_T_STATES,
    parameter int LEN_W = $clog2(NUM_T - T_MIN + 1),
    parameter int SEL_W = $clog2(NUM_M + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic [LEN_W-1:0] cyc_len,
    input  logic [SEL_W-1:0] next_m,
    output logic [NUM_M-1:0] m_ring,
    output logic [NUM_T-1:0] t_ring
);
    logic             stalled;
    logic             cycle_end;
    logic [NUM_T-1:0] t_cur;

    mt_wait_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .stalled  (stalled)
    );

    mt_tstate_ring #(.NUM_T(NUM_T), .T_MIN(T_MIN), .LEN_W(LEN_W)) u_tring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!stalled),
        .cyc_len   (cyc_len),
        .t_cur     (t_cur),
        .cycle_end (cycle_end)
    );

    mt_mcycle_ring #(.NUM_M(NUM_M), .SEL_W(SEL_W)) u_mring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cycle_end),
        .next_sel (next_m),
        .m_cur    (m_ring)
    );

    always_comb begin
        t_ring = stalled ? '0 : t_cur;
    end

    // R8: one-hot rings outside a stall
    a_r8_m_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_ring) == 1);
    a_r8_t_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !stalled |-> ($countones(t_ring) == 1));
    // R6: a wait seen while running blanks the clock-state ring
    a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!stalled && wait_req) |=> (t_ring == '0));
    // R7: release restores the remembered state, machine cycle frozen
    a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !wait_req) |=> (t_ring == $past(t_cur)));
    a_r7_m_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> $stable(m_ring));
endmodule

// File: tb/sim_mt_ring_sequencer.sv
module sim_mt_ring_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wait_req = 1'b0;
    logic [1:0] cyc_len = 2'd0;
    logic [2:0] next_m = 3'd0;
    logic [4:0] m_ring;
    logic [5:0] t_ring;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    int  em = 0;
    int  et = 0;
    bit  es = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mt_ring_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req),
        .cyc_len(cyc_len), .next_m(next_m),
        .m_ring(m_ring), .t_ring(t_ring)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] cl, input logic [2:0] nm);
        bit    ended = 0;
        bit    resumed = 0;
        bit    was_stalled = es;
        string ttag, mtag;
        wait_req = w; cyc_len = cl; next_m = nm;
        if (!es) begin
            if (et >= int'(cl) + 2) begin
                et = 0; ended = 1;
                em = (nm < 5) ? int'(nm) : 0;
            end else begin
                et++;
            end
            es = w;
        end else if (!w) begin
            es = 0; resumed = 1;
        end
        @(posedge clk);
        @(negedge clk);
        ttag = es ? "R6" : (resumed ? "R7" : (ended ? "R3" : "R2"));
        mtag = was_stalled ? "R7" : (ended ? ((nm >= 5) ? "R5" : "R4") : "R9");
        check(mtag, {3'b0, m_ring}, 8'(1 << em));
        check(ttag, {2'b0, t_ring}, es ? 8'h00 : 8'(1 << et));
        if (!es) check("R8", 8'($countones(t_ring) + $countones(m_ring)), 8'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R1", {3'b0, m_ring}, 8'h01);
        check("R1", {2'b0, t_ring}, 8'h01);
        rst_n = 1'b1;
        // every length code against every next-cycle select
        for (int cl = 0; cl < 4; cl++)
            for (int nm = 0; nm < 8; nm++)
                for (int k = 0; k < cl + 3; k++)
                    step(1'b0, 2'(cl), 3'(nm));
        // three-cycle pop pattern M1 -> M4 -> M5 -> M1
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, 3'd3);
        check("R4", {3'b0, m_ring}, 8'h08);
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, 3'd4);
        check("R4", {3'b0, m_ring}, 8'h10);
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, 3'd0);
        check("R4", {3'b0, m_ring}, 8'h01);
        // stalls of each length at each position of a six-state cycle
        for (int p = 0; p < 6; p++)
            for (int l = 1; l < 4; l++)
                for (int k = 0; k < 6 + l; k++)
                    step((k >= p) && (k < p + l), 2'd3, 3'(p % 5));
        // pseudo-random inputs changing mid-cycle
        for (int k = 0; k < 800; k++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step(lf[1:0] == 2'b00, lf[5:4], lf[10:8]);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule